// File: doc/BRIEF.md
# Rotating-Seed Hyperdimensional Feature Encoder

This block turns one sample of quantized input features into a hypervector of per-dimension counts. Every feature carries a small level code that picks one of a fixed set of level hypervectors held in on-chip memory. The chosen level bits are bound by XOR to a position hypervector, and the bound bits are then summed across all features for every dimension. The position hypervectors are not stored one by one. A single seed hypervector is held, and the position vector of feature `i` is that seed rotated by `i` places.

The hypervector is produced in slices of `DBLK` dimensions. Per clock, `SLOTS` features are handled together. Each slot has its own copy of the level memory, addressed by the feature's code. One window of `DBLK+SLOTS-1` seed bits is read per clock and fanned out to the slots at fixed offsets. The per-column popcounts are added into a running-sum buffer over `ceil(NUM_FEAT/SLOTS)` feature groups. After the last group, the finished slice is emitted with its slice index.

Before a start is issued, software-side logic preloads the level memory, the seed and the feature codes. The popcount per column is either exact, or an approximate local-majority count over groups of six slots.

Top module: `hde_encoder`

## Requirements
- R1: After reset `out_valid` is low, and it stays low until a start has been accepted.
- R2: A feature whose code is `v` (4-bit code, 16 levels) contributes bit `k` of level hypervector `v`. A level write with `lvl_sel`=v, `lvl_blk`=b and `lvl_data` stores dimensions `b*DBLK+t` at data bit `t`, for every slot copy at once.
- R3: Feature `i` (counted from 0) is bound to position bit `seed[(k+i) mod HV_LEN]` for dimension `k`. Rotation wraps past the top of the seed.
- R4: In exact mode, column `t` of slice `b` equals the number of features `i < NUM_FEAT` for which `level[v_i][k] XOR seed[(k+i) mod HV_LEN]` is 1, with `k = b*DBLK+t`. Column `t` occupies `out_cnt[t*CW +: CW]`, with `CW = clog2(NUM_FEAT+1)`.
- R5: One encoding emits slices 0 through `HV_LEN/DBLK-1` in increasing order on `out_blk`, exactly once each.
- R6: With `G = ceil(NUM_FEAT/SLOTS)`, slice `b` is valid for exactly one cycle. It appears `(b+1)*G+1` clock edges after the edge that accepted the start, so consecutive slices are `G` cycles apart.
- R7: A start that arrives while an encoding is running has no effect: the slice sequence and its timing are unchanged, and no further slices follow.
- R8: Slots in the final group whose feature index is `NUM_FEAT` or above add nothing, so no count exceeds `NUM_FEAT`. With all bound bits at 1, every count is exactly `NUM_FEAT`.
- R9: The running sum restarts at each slice. Repeating an encoding on the same data gives identical results, whatever was encoded before.
- R10: In majority mode, within each feature group, slots `6s..6s+5` form voter `s` (a partial last voter takes fewer slots, and masked slots read 0). A voter yields 1 if more than 3 of its bits are 1, or exactly 3 are 1 and bit `t` of `TIE_MASK` is 1. Column `t` is the sum of all voter outputs over all groups.
- R11: A seed write with `seed_blk`=b stores `seed_data` bit `t` as seed bit `b*DBLK+t`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| feat_we | input | 1 | Write one feature code |
| feat_idx | input | FW | Feature index to write |
| feat_val | input | LW | Quantized level code of that feature |
| lvl_we | input | 1 | Write one slice of a level hypervector |
| lvl_sel | input | LW | Level number to write |
| lvl_blk | input | BW | Dimension slice to write |
| lvl_data | input | DBLK | Slice contents |
| seed_we | input | 1 | Write one slice of the seed |
| seed_blk | input | BW | Seed slice to write |
| seed_data | input | DBLK | Seed slice contents |
| start | input | 1 | Begin an encoding (ignored while busy) |
| out_valid | output | 1 | A finished slice is on `out_cnt` |
| out_blk | output | BW | Index of the emitted slice |
| out_cnt | output | DBLK*CW | Per-dimension counts, column t at `[t*CW +: CW]` |

## Verification
The bound checker inspects the emitted stream on every cycle. It confirms that nothing is emitted before the first start, that slices leave in order starting from zero, that slices within one encoding are exactly `G` cycles apart, and that no count ever exceeds the feature count. The bench scenarios are the only means of showing the arithmetic itself. That covers the level-code addressing, the wrap-around of the rotated seed, the masking of padding slots, the tie-breaking majority count, and that a stray start in mid-run changes nothing. Each of these is checked against counts the bench computes from its own copy of the preloaded data.

// File: rtl/hde_pkg.sv
package hde_pkg;

    typedef enum logic [0:0] {
        TREE_EXACT = 1'b0,
        TREE_MAJ6  = 1'b1
    } tree_mode_e;

    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

endpackage

// File: rtl/hde_level_bank.sv
// One slot's private copy of all level hypervectors, one slice per word.
module hde_level_bank #(
    parameter int DBLK   = 64,
    parameter int LEVELS = 16,
    parameter int BLOCKS = 8,
    parameter int LW     = 4,
    parameter int BW     = 3
) (
    input  logic            clk,
    input  logic            wr_en,
    input  logic [LW-1:0]   wr_lvl,
    input  logic [BW-1:0]   wr_blk,
    input  logic [DBLK-1:0] wr_data,
    input  logic            rd_en,
    input  logic [LW-1:0]   rd_lvl,
    input  logic [BW-1:0]   rd_blk,
    output logic [DBLK-1:0] rd_data
);
    localparam int DEPTH = LEVELS * BLOCKS;

    logic [DBLK-1:0] mem_q [DEPTH];
    logic [DBLK-1:0] rd_d;
    logic [DBLK-1:0] rd_q;

    always_comb begin
        rd_d = rd_q;
        if (rd_en) begin
            rd_d = mem_q[int'(rd_lvl) * BLOCKS + int'(rd_blk)];
        end
    end

    always_ff @(posedge clk) begin
        rd_q <= rd_d;
        if (wr_en) begin
            mem_q[int'(wr_lvl) * BLOCKS + int'(wr_blk)] <= wr_data;
        end
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/hde_seed_window.sv
// Holds the seed hypervector; returns a wrapped window of consecutive bits.
module hde_seed_window #(
    parameter int DBLK   = 64,
    parameter int HV_LEN = 512,
    parameter int WIN    = 71,
    parameter int BW     = 3,
    parameter int AW     = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [BW-1:0]   wr_blk,
    input  logic [DBLK-1:0] wr_data,
    input  logic [AW-1:0]   rd_start,
    output logic [WIN-1:0]  rd_win
);
    logic [HV_LEN-1:0] seed_d, seed_q;
    logic [WIN-1:0]    win_d, win_q;

    always_comb begin
        seed_d = seed_q;
        if (wr_en) begin
            seed_d[int'(wr_blk) * DBLK +: DBLK] = wr_data;
        end
        for (int w = 0; w < WIN; w++) begin
            int pos;
            pos = int'(rd_start) + w;
            if (pos >= HV_LEN) begin
                pos = pos - HV_LEN;
            end
            win_d[w] = seed_q[pos];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seed_q <= '0;
            win_q  <= '0;
        end else begin
            seed_q <= seed_d;
            win_q  <= win_d;
        end
    end

    assign rd_win = win_q;
endmodule

// File: rtl/hde_popcount.sv
// Column counter: exact sum of NIN bits, or sum of six-bit local majorities.
module hde_popcount #(
    parameter int                  NIN  = 8,
    parameter int                  OW   = 5,
    parameter hde_pkg::tree_mode_e MODE = hde_pkg::TREE_EXACT,
    parameter bit                  TIE  = 1'b0
) (
    input  logic [NIN-1:0] bits_in,
    output logic [OW-1:0]  count
);
    localparam int VOTERS = hde_pkg::ceil_div(NIN, 6);

    generate
        if (MODE == hde_pkg::TREE_EXACT) begin : g_exact
            always_comb begin
                count = '0;
                for (int j = 0; j < NIN; j++) begin
                    count = count + OW'(bits_in[j]);
                end
            end
        end else begin : g_maj
            always_comb begin
                count = '0;
                for (int s = 0; s < VOTERS; s++) begin
                    int ones;
                    ones = 0;
                    for (int j = 0; j < 6; j++) begin
                        if (s * 6 + j < NIN) begin
                            ones = ones + int'(bits_in[s * 6 + j]);
                        end
                    end
                    if (ones > 3 || (ones == 3 && TIE)) begin
                        count = count + OW'(1);
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/hde_encoder.sv
module hde_encoder #(
    parameter int                  NUM_FEAT  = 20,
    parameter int                  SLOTS     = 8,
    parameter int                  DBLK      = 64,
    parameter int                  HV_LEN    = 512,
    parameter int                  LEVELS    = 16,
    parameter hde_pkg::tree_mode_e TREE_MODE = hde_pkg::TREE_EXACT,
    parameter logic [DBLK-1:0]     TIE_MASK  = {(DBLK/2){2'b10}},
    localparam int GROUPS = hde_pkg::ceil_div(NUM_FEAT, SLOTS),
    localparam int BLOCKS = HV_LEN / DBLK,
    localparam int WIN    = DBLK + SLOTS - 1,
    localparam int LW     = (LEVELS > 1) ? $clog2(LEVELS) : 1,
    localparam int BW     = (BLOCKS > 1) ? $clog2(BLOCKS) : 1,
    localparam int GW     = (GROUPS > 1) ? $clog2(GROUPS) : 1,
    localparam int FW     = (NUM_FEAT > 1) ? $clog2(NUM_FEAT) : 1,
    localparam int AW     = $clog2(HV_LEN),
    localparam int CW     = $clog2(NUM_FEAT + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 feat_we,
    input  logic [FW-1:0]        feat_idx,
    input  logic [LW-1:0]        feat_val,
    input  logic                 lvl_we,
    input  logic [LW-1:0]        lvl_sel,
    input  logic [BW-1:0]        lvl_blk,
    input  logic [DBLK-1:0]      lvl_data,
    input  logic                 seed_we,
    input  logic [BW-1:0]        seed_blk,
    input  logic [DBLK-1:0]      seed_data,
    input  logic                 start,
    output logic                 out_valid,
    output logic [BW-1:0]        out_blk,
    output logic [DBLK*CW-1:0]   out_cnt
);
    localparam logic [GW-1:0] GRP_LAST = GW'(GROUPS - 1);
    localparam logic [BW-1:0] BLK_LAST = BW'(BLOCKS - 1);

    typedef struct packed {
        logic                      busy;
        logic [BW-1:0]             blk;
        logic [GW-1:0]             grp;
        logic                      s1_valid;
        logic [BW-1:0]             s1_blk;
        logic                      s1_first;
        logic                      s1_last;
        logic [SLOTS-1:0]          s1_mask;
        logic                      out_valid;
        logic [BW-1:0]             out_blk;
        logic [DBLK-1:0][CW-1:0]   acc;
    } ctl_t;

    ctl_t r_d, r_q;

    // Feature code file
    logic [LW-1:0] feat_q [NUM_FEAT];

    always_ff @(posedge clk) begin
        if (feat_we) begin
            feat_q[feat_idx] <= feat_val;
        end
    end

    // Slot selection for the group being issued
    logic [SLOTS-1:0][LW-1:0] slot_val;
    logic [SLOTS-1:0]         slot_ok;
    logic [AW-1:0]            win_start;

    always_comb begin
        for (int j = 0; j < SLOTS; j++) begin
            int fidx;
            fidx = int'(r_q.grp) * SLOTS + j;
            slot_ok[j]  = (fidx < NUM_FEAT);
            slot_val[j] = slot_ok[j] ? feat_q[fidx % NUM_FEAT] : '0;
        end
        win_start = AW'((int'(r_q.blk) * DBLK + int'(r_q.grp) * SLOTS) % HV_LEN);
    end

    // Memories: one level bank per slot, one shared seed window
    logic [SLOTS-1:0][DBLK-1:0] lvl_rd;
    logic [WIN-1:0]             win;

    generate
        for (genvar j = 0; j < SLOTS; j++) begin : g_slot
            hde_level_bank #(
                .DBLK(DBLK), .LEVELS(LEVELS), .BLOCKS(BLOCKS), .LW(LW), .BW(BW)
            ) u_bank (
                .clk     (clk),
                .wr_en   (lvl_we),
                .wr_lvl  (lvl_sel),
                .wr_blk  (lvl_blk),
                .wr_data (lvl_data),
                .rd_en   (r_q.busy),
                .rd_lvl  (slot_val[j]),
                .rd_blk  (r_q.blk),
                .rd_data (lvl_rd[j])
            );
        end
    endgenerate

    hde_seed_window #(
        .DBLK(DBLK), .HV_LEN(HV_LEN), .WIN(WIN), .BW(BW), .AW(AW)
    ) u_seed (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (seed_we),
        .wr_blk   (seed_blk),
        .wr_data  (seed_data),
        .rd_start (win_start),
        .rd_win   (win)
    );

    // Binding and per-column popcount
    logic [DBLK-1:0][SLOTS-1:0] col;
    logic [DBLK-1:0][CW-1:0]    pop;

    always_comb begin
        for (int t = 0; t < DBLK; t++) begin
            for (int j = 0; j < SLOTS; j++) begin
                col[t][j] = r_q.s1_mask[j] & (lvl_rd[j][t] ^ win[j + t]);
            end
        end
    end

    generate
        for (genvar t = 0; t < DBLK; t++) begin : g_col
            hde_popcount #(
                .NIN(SLOTS), .OW(CW), .MODE(TREE_MODE), .TIE(TIE_MASK[t])
            ) u_pop (
                .bits_in (col[t]),
                .count   (pop[t])
            );
        end
    endgenerate

    // Next-state logic
    always_comb begin
        r_d           = r_q;
        r_d.out_valid = 1'b0;

        r_d.s1_valid = r_q.busy;
        r_d.s1_blk   = r_q.blk;
        r_d.s1_first = (r_q.grp == '0);
        r_d.s1_last  = (r_q.grp == GRP_LAST);
        r_d.s1_mask  = slot_ok;

        if (r_q.busy) begin
            if (r_q.grp == GRP_LAST) begin
                r_d.grp = '0;
                if (r_q.blk == BLK_LAST) begin
                    r_d.busy = 1'b0;
                end else begin
                    r_d.blk = r_q.blk + BW'(1);
                end
            end else begin
                r_d.grp = r_q.grp + GW'(1);
            end
        end else if (start) begin
            r_d.busy = 1'b1;
            r_d.blk  = '0;
            r_d.grp  = '0;
        end

        if (r_q.s1_valid) begin
            for (int t = 0; t < DBLK; t++) begin
                r_d.acc[t] = (r_q.s1_first ? '0 : r_q.acc[t]) + pop[t];
            end
            if (r_q.s1_last) begin
                r_d.out_valid = 1'b1;
                r_d.out_blk   = r_q.s1_blk;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_valid = r_q.out_valid;
    assign out_blk   = r_q.out_blk;
    assign out_cnt   = r_q.acc;
endmodule

// File: rtl/hde_encoder_chk.sv
module hde_encoder_chk #(
    parameter int NUM_FEAT = 20,
    parameter int SLOTS    = 8,
    parameter int DBLK     = 64,
    parameter int HV_LEN   = 512,
    parameter int BW       = 3,
    parameter int CW       = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               out_valid,
    input logic [BW-1:0]      out_blk,
    input logic [DBLK*CW-1:0] out_cnt
);
    localparam int GROUPS = hde_pkg::ceil_div(NUM_FEAT, SLOTS);
    localparam int BLOCKS = HV_LEN / DBLK;
    localparam logic [BW-1:0] BLK_LAST = BW'(BLOCKS - 1);

    logic          started_q;
    logic          run_open_q;
    logic [BW-1:0] prev_blk_q;
    logic [15:0]   gap_q;
    logic          over_any;

    always_comb begin
        over_any = 1'b0;
        for (int t = 0; t < DBLK; t++) begin
            if (int'(out_cnt[t*CW +: CW]) > NUM_FEAT) begin
                over_any = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            started_q  <= 1'b0;
            run_open_q <= 1'b0;
            prev_blk_q <= '0;
            gap_q      <= '0;
        end else begin
            if (start) begin
                started_q <= 1'b1;
            end
            if (out_valid) begin
                prev_blk_q <= out_blk;
                run_open_q <= (out_blk != BLK_LAST);
                gap_q      <= '0;
            end else if (gap_q != 16'hffff) begin
                gap_q <= gap_q + 16'd1;
            end
        end
    end

    a_r1_quiet_before_start: assert property (@(posedge clk) disable iff (!rst_n)
        !started_q |-> !out_valid);

    a_r5_first_block_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !run_open_q) |-> (out_blk == '0));

    a_r5_block_order: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && run_open_q) |-> (out_blk == prev_blk_q + BW'(1)));

    a_r6_block_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && run_open_q) |-> (int'(gap_q) == GROUPS - 1));

    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !over_any);
endmodule

bind hde_encoder hde_encoder_chk #(
    .NUM_FEAT(NUM_FEAT), .SLOTS(SLOTS), .DBLK(DBLK), .HV_LEN(HV_LEN), .BW(BW), .CW(CW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .out_valid (out_valid),
    .out_blk   (out_blk),
    .out_cnt   (out_cnt)
);

// File: tb/hde_encoder_test.sv
module hde_encoder_test;
    localparam int NF     = 20;
    localparam int P      = 8;
    localparam int DB     = 64;
    localparam int D      = 512;
    localparam int L      = 16;
    localparam int G      = (NF + P - 1) / P;
    localparam int B      = D / DB;
    localparam int LW     = 4;
    localparam int BW     = 3;
    localparam int FW     = 5;
    localparam int CW     = 5;
    localparam logic [DB-1:0] TIE = 64'h9c3a_5e71_0fd2_b846;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic feat_we = 1'b0;
    logic [FW-1:0] feat_idx = '0;
    logic [LW-1:0] feat_val = '0;
    logic lvl_we = 1'b0;
    logic [LW-1:0] lvl_sel = '0;
    logic [BW-1:0] lvl_blk = '0;
    logic [DB-1:0] lvl_data = '0;
    logic seed_we = 1'b0;
    logic [BW-1:0] seed_blk = '0;
    logic [DB-1:0] seed_data = '0;
    logic start = 1'b0;
    logic out_valid, mj_valid;
    logic [BW-1:0] out_blk, mj_blk;
    logic [DB*CW-1:0] out_cnt, mj_cnt;

    always #2 clk = ~clk;

    hde_encoder #(.NUM_FEAT(NF), .SLOTS(P), .DBLK(DB), .HV_LEN(D), .LEVELS(L),
                  .TREE_MODE(hde_pkg::TREE_EXACT), .TIE_MASK(TIE)) uut (
        .clk(clk), .rst_n(rst_n), .feat_we(feat_we), .feat_idx(feat_idx), .feat_val(feat_val),
        .lvl_we(lvl_we), .lvl_sel(lvl_sel), .lvl_blk(lvl_blk), .lvl_data(lvl_data),
        .seed_we(seed_we), .seed_blk(seed_blk), .seed_data(seed_data), .start(start),
        .out_valid(out_valid), .out_blk(out_blk), .out_cnt(out_cnt));

    hde_encoder #(.NUM_FEAT(NF), .SLOTS(P), .DBLK(DB), .HV_LEN(D), .LEVELS(L),
                  .TREE_MODE(hde_pkg::TREE_MAJ6), .TIE_MASK(TIE)) uut_maj (
        .clk(clk), .rst_n(rst_n), .feat_we(feat_we), .feat_idx(feat_idx), .feat_val(feat_val),
        .lvl_we(lvl_we), .lvl_sel(lvl_sel), .lvl_blk(lvl_blk), .lvl_data(lvl_data),
        .seed_we(seed_we), .seed_blk(seed_blk), .seed_data(seed_data), .start(start),
        .out_valid(mj_valid), .out_blk(mj_blk), .out_cnt(mj_cnt));

    bit lvl_m [L][D];
    bit seed_m [D];
    int feat_m [NF];
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    function automatic int bound_bit(int i, int k);
        return int'(lvl_m[feat_m[i]][k] ^ seed_m[(k + i) % D]);
    endfunction

    function automatic int exp_exact(int b, int t);
        int s = 0;
        for (int i = 0; i < NF; i++) s += bound_bit(i, b * DB + t);
        return s;
    endfunction

    function automatic int exp_maj(int b, int t);
        int s = 0;
        for (int g = 0; g < G; g++) begin
            for (int v = 0; v < (P + 5) / 6; v++) begin
                int ones = 0;
                for (int j = v * 6; j < v * 6 + 6 && j < P; j++) begin
                    if (g * P + j < NF) ones += bound_bit(g * P + j, b * DB + t);
                end
                if (ones > 3 || (ones == 3 && TIE[t])) s++;
            end
        end
        return s;
    endfunction

    task automatic check(bit ok, string req, int got, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic load_all();
        for (int l = 0; l < L; l++) begin
            for (int b = 0; b < B; b++) begin
                @(negedge clk);
                lvl_we = 1'b1; lvl_sel = LW'(l); lvl_blk = BW'(b);
                for (int t = 0; t < DB; t++) lvl_data[t] = lvl_m[l][b * DB + t];
            end
        end
        for (int b = 0; b < B; b++) begin
            @(negedge clk);
            lvl_we = 1'b0; seed_we = 1'b1; seed_blk = BW'(b);
            for (int t = 0; t < DB; t++) seed_data[t] = seed_m[b * DB + t];
        end
        for (int i = 0; i < NF; i++) begin
            @(negedge clk);
            seed_we = 1'b0; feat_we = 1'b1;
            feat_idx = FW'(i); feat_val = LW'(feat_m[i]);
        end
        @(negedge clk);
        lvl_we = 1'b0; seed_we = 1'b0; feat_we = 1'b0;
    endtask

    // Runs one encoding and checks timing, order and every count.
    task automatic run_encode(string tag, bit mid_start);
        bit tim_ok = 1'b1;
        int tim_k = 0;
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int k = 1; k <= B * G + 2 * G; k++) begin
            bit expv;
            int b;
            start = (mid_start && k == G + 2);
            @(posedge clk);
            @(negedge clk);
            expv = (k >= G + 1) && ((k - 1) % G == 0) && ((k - 1) / G <= B);
            b = (k - 1) / G - 1;
            if (out_valid !== expv || mj_valid !== expv) begin
                if (tim_ok) tim_k = k;
                tim_ok = 1'b0;
            end
            if (expv && out_valid) begin
                int bad_t = -1;
                int bad_m = -1;
                check(out_blk == BW'(b), {"R5 slice index ", tag}, int'(out_blk), b);
                for (int t = 0; t < DB; t++) begin
                    if (bad_t < 0 && int'(out_cnt[t*CW +: CW]) != exp_exact(b, t)) bad_t = t;
                    if (bad_m < 0 && int'(mj_cnt[t*CW +: CW]) != exp_maj(b, t)) bad_m = t;
                end
                if (bad_t < 0) check(1'b1, "", 0, 0);
                else check(1'b0, $sformatf("R4 %s slice %0d col %0d", tag, b, bad_t),
                           int'(out_cnt[bad_t*CW +: CW]), exp_exact(b, bad_t));
                if (bad_m < 0) check(1'b1, "", 0, 0);
                else check(1'b0, $sformatf("R10 %s slice %0d col %0d", tag, b, bad_m),
                           int'(mj_cnt[bad_m*CW +: CW]), exp_maj(b, bad_m));
            end
        end
        start = 1'b0;
        check(tim_ok, $sformatf("R6 %s valid timing at edge", tag), tim_k, 0);
    endtask

    task automatic fill_random();
        for (int l = 0; l < L; l++) for (int k = 0; k < D; k++) lvl_m[l][k] = 1'($urandom);
        for (int k = 0; k < D; k++) seed_m[k] = 1'($urandom);
        for (int i = 0; i < NF; i++) feat_m[i] = int'($urandom % L);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && mj_valid == 1'b0, "R1 valid low in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        repeat (10) begin
            @(negedge clk);
            if (out_valid || mj_valid) check(1'b0, "R1 valid before start", 1, 0);
        end
        check(out_valid == 1'b0, "R1 idle after reset", int'(out_valid), 0);

        // Random data: addressing, rotation, preload paths (R2 R3 R11)
        fill_random();
        load_all();
        run_encode("R2 R3 R11 random", 1'b0);

        // Re-run on same data with a stray start mid-run (R7 R9)
        run_encode("R7 R9 restart", 1'b1);

        // All bound bits one: counts equal feature count (R8)
        for (int l = 0; l < L; l++) for (int k = 0; k < D; k++) lvl_m[l][k] = (l == 15);
        for (int k = 0; k < D; k++) seed_m[k] = 1'b0;
        for (int i = 0; i < NF; i++) feat_m[i] = 15;
        load_all();
        run_encode("R8 full count", 1'b0);
        for (int t = 0; t < DB; t++) begin
            if (int'(out_cnt[t*CW +: CW]) != NF)
                check(1'b0, "R8 last slice full count", int'(out_cnt[t*CW +: CW]), NF);
        end
        check(1'b1, "", 0, 0);

        // One-hot seed, zero levels: exposes rotation wrap (R3)
        for (int l = 0; l < L; l++) for (int k = 0; k < D; k++) lvl_m[l][k] = 1'b0;
        for (int k = 0; k < D; k++) seed_m[k] = (k == 0);
        load_all();
        run_encode("R3 wrap one-hot", 1'b0);

        // Further random patterns, with tie-heavy sparse data for R10
        for (int r = 0; r < 3; r++) begin
            fill_random();
            if (r == 1) for (int k = 0; k < D; k++) seed_m[k] = 1'b0;
            load_all();
            run_encode($sformatf("R4 R10 random%0d", r), 1'b0);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule